// File: doc/BRIEF.md
# Register-Target Branch Resolution Unit

This block resolves the control-flow instructions of a core whose branch destinations live in a small bank of target registers. The destination is never carried in the instruction word. A 3-bit field in the word picks one of eight 64-bit target registers. From the instruction word, the two source operand values, the current program counter and the whole target bank, the unit works out four things: whether the branch is taken, the next program counter, the static "likely" hint, and any write-back to a general register. It covers three instruction groups:

- register-register compares;
- register-immediate compares;
- the branch-and-link / read-target group.

Instructions go in and results come out over valid/ready streams. A transfer happens on a rising clock edge when valid and ready are both high. When the optional output register is enabled (the default), a result appears one cycle after its input is accepted. The result is held unchanged while `out_ready` is low, and `in_ready` drops while a held result blocks the slot. When the register is disabled, the block is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. The target bank and operands are sampled together with the instruction.

Top module: `brt_resolve_unit`

## Requirements
- R1: Opcode 25 (instruction bits 31:26) compares operand A with operand B. The test is chosen by the extension field in bits 19:16: 1 equal, 5 not equal, 3 signed greater-or-equal, 7 signed greater-than, 11 unsigned greater-or-equal, 15 unsigned greater-than.
- R2: Opcode 57 compares operand A with the 6-bit field in bits 15:10, sign-extended to 64 bits. Extension 1 tests equal and extension 5 tests not equal. Operand B has no effect.
- R3: For a compare whose test holds, `out_taken`=1 and `out_next_pc` is the target register selected by bits 6:4. Otherwise `out_next_pc` is PC+4.
- R4: `out_likely` carries instruction bit 9 for well-formed compare instructions and is 0 for every other instruction.
- R5: Opcode 17 with extension 1 (branch-and-link) is always taken to the target register selected by bits 22:20. It writes (PC+4) with bit 0 forced to 1 to the general register numbered by bits 9:4, given on `out_link_dest`.
- R6: Opcode 17 with extension 5 writes the target register selected by bits 22:20 to the register named by bits 9:4. It is not taken, and the next PC is PC+4.
- R7: A recognised opcode is malformed when any of these holds: its extension is not listed in R1/R2/R5/R6; bits 3:0 are non-zero; for opcodes 25/57, bits 8:7 are non-zero; for opcode 17, bits 25:23 are non-zero or bits 15:10 are not all ones. A malformed instruction sets `out_illegal`=1, `out_taken`=0, `out_link_we`=0, `out_likely`=0, and the next PC is PC+4.
- R8: Any other opcode gives `out_taken`=0, `out_link_we`=0, `out_illegal`=0 and next PC = PC+4.
- R9: With the output register enabled, a result is presented one cycle after acceptance. While `out_valid`=1 and `out_ready`=0, the result stays stable and `in_ready`=0.
- R10: After reset, `out_valid` is 0 until an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 64 | Value of the left source register |
| in_opb | input | 64 | Value of the right source register |
| in_pc | input | 64 | Address of the instruction |
| in_tr_bank | input | 512 | Eight target registers, entry i at bits 64*i+63:64*i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 64 | Next program counter |
| out_likely | output | 1 | Static likely hint |
| out_link_we | output | 1 | General register write request |
| out_link_dest | output | 6 | General register number to write |
| out_link_data | output | 64 | Value to write |
| out_illegal | output | 1 | Malformed encoding |

## Verification
The bench targets the signed/unsigned boundary with an all-ones operand against one. A comparator using the wrong signedness flips that outcome and sends the PC to the wrong place. It compares against an immediate of all ones and of plain 63 to expose a zero-extended immediate, checks that the link value is odd and offset by four, and checks that the read-target form never redirects the PC. Each must-be-zero field and an unknown extension are set one at a time. A design that misses one of them would branch or write a register on a corrupt word. Back-pressure is applied across two instructions to catch a result that changes, or an input that is taken, while the output is stalled.

// File: rtl/brt_pkg.sv
package brt_pkg;

  // Instruction field geometry (fixed by the encoding)
  localparam int ILEN       = 32;
  localparam int OP_W       = 6;
  localparam int EXT_W      = 4;
  localparam int REG_W      = 6;
  localparam int TRSEL_W    = 3;
  localparam int IMM_W      = 6;

  localparam logic [OP_W-1:0] OPC_CMP_REG = 6'd25;
  localparam logic [OP_W-1:0] OPC_CMP_IMM = 6'd57;
  localparam logic [OP_W-1:0] OPC_TRGRP   = 6'd17;

  typedef enum logic [2:0] {
    K_NONE,
    K_CMP_REG,
    K_CMP_IMM,
    K_LINK,
    K_MOVE
  } kind_e;

  typedef enum logic [2:0] {
    C_EQ,
    C_NE,
    C_GE,
    C_GT,
    C_GEU,
    C_GTU
  } cond_e;

  typedef struct packed {
    kind_e               kind;
    cond_e               cond;
    logic [TRSEL_W-1:0]  tr_sel;
    logic [REG_W-1:0]    dest;
    logic [IMM_W-1:0]    imm;
    logic                hint;
    logic                bad;
  } dec_t;

endpackage

// File: rtl/brt_decode.sv
module brt_decode
  import brt_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);

  logic [OP_W-1:0]  opc;
  logic [EXT_W-1:0] ext;
  logic [2:0]       hi_gap;
  logic [5:0]       right_f;
  logic [1:0]       mid_gap;
  logic [3:0]       tail;

  assign opc     = instr[31:26];
  assign hi_gap  = instr[25:23];
  assign ext     = instr[19:16];
  assign right_f = instr[15:10];
  assign mid_gap = instr[8:7];
  assign tail    = instr[3:0];

  always_comb begin
    dec        = '0;
    dec.kind   = K_NONE;
    dec.cond   = C_EQ;
    dec.dest   = instr[9:4];
    dec.imm    = right_f;
    dec.hint   = instr[9];
    dec.tr_sel = instr[6:4];
    unique case (opc)
      OPC_CMP_REG: begin
        dec.kind = K_CMP_REG;
        unique case (ext)
          4'd1:    dec.cond = C_EQ;
          4'd5:    dec.cond = C_NE;
          4'd3:    dec.cond = C_GE;
          4'd7:    dec.cond = C_GT;
          4'd11:   dec.cond = C_GEU;
          4'd15:   dec.cond = C_GTU;
          default: dec.bad  = 1'b1;
        endcase
        if (mid_gap != '0 || tail != '0) dec.bad = 1'b1;
      end
      OPC_CMP_IMM: begin
        dec.kind = K_CMP_IMM;
        unique case (ext)
          4'd1:    dec.cond = C_EQ;
          4'd5:    dec.cond = C_NE;
          default: dec.bad  = 1'b1;
        endcase
        if (mid_gap != '0 || tail != '0) dec.bad = 1'b1;
      end
      OPC_TRGRP: begin
        dec.tr_sel = instr[22:20];
        unique case (ext)
          4'd1:    dec.kind = K_LINK;
          4'd5:    dec.kind = K_MOVE;
          default: begin
            dec.kind = K_LINK;
            dec.bad  = 1'b1;
          end
        endcase
        if (hi_gap != '0 || right_f != '1 || tail != '0) dec.bad = 1'b1;
      end
      default: dec.kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/brt_compare.sv
module brt_compare
  import brt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cond_e            cond,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic             hit
);

  logic [XLEN-1:0] rhs;
  logic            eq, gt_s, gt_u;

  assign rhs  = use_imm ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} : opb;
  assign eq   = (opa == rhs);
  assign gt_s = ($signed(opa) > $signed(rhs));
  assign gt_u = (opa > rhs);

  always_comb begin
    unique case (cond)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_GE:    hit = gt_s || eq;
      C_GT:    hit = gt_s;
      C_GEU:   hit = gt_u || eq;
      C_GTU:   hit = gt_u;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brt_tr_select.sv
module brt_tr_select
  import brt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [(1<<TRSEL_W)*XLEN-1:0] bank,
  input  logic [TRSEL_W-1:0]           sel,
  output logic [XLEN-1:0]              value
);

  localparam int NTR = 1 << TRSEL_W;

  logic [XLEN-1:0] entry [NTR];

  for (genvar g = 0; g < NTR; g++) begin : g_unpack
    assign entry[g] = bank[g*XLEN +: XLEN];
  end

  assign value = entry[sel];

endmodule

// File: rtl/brt_out_stage.sv
module brt_out_stage #(
  parameter int PW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  if (OUT_REG) begin : g_reg
    logic          vld_q;
    logic [PW-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_valid && in_ready) begin
        vld_q <= 1'b1;
        dat_q <= in_data;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    // R9: a stalled result stays put
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: no acceptance while a stalled result occupies the slot
    a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/brt_resolve_unit.sv
module brt_resolve_unit
  import brt_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [ILEN-1:0]               in_instr,
  input  logic [XLEN-1:0]               in_opa,
  input  logic [XLEN-1:0]               in_opb,
  input  logic [XLEN-1:0]               in_pc,
  input  logic [(1<<TRSEL_W)*XLEN-1:0]  in_tr_bank,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_taken,
  output logic [XLEN-1:0]               out_next_pc,
  output logic                          out_likely,
  output logic                          out_link_we,
  output logic [REG_W-1:0]              out_link_dest,
  output logic [XLEN-1:0]               out_link_data,
  output logic                          out_illegal
);

  localparam int PW = 2*XLEN + REG_W + 4;

  dec_t            dec;
  logic            cmp_hit;
  logic            is_cmp;
  logic            legal;
  logic [XLEN-1:0] tr_val;
  logic [XLEN-1:0] seq_pc;

  logic            r_taken, r_likely, r_we, r_illegal;
  logic [XLEN-1:0] r_npc, r_ldata;
  logic [PW-1:0]   pay_in, pay_out;

  brt_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  brt_compare #(.XLEN(XLEN)) u_cmp (
    .cond    (dec.cond),
    .use_imm (dec.kind == K_CMP_IMM),
    .imm     (dec.imm),
    .opa     (in_opa),
    .opb     (in_opb),
    .hit     (cmp_hit)
  );

  brt_tr_select #(.XLEN(XLEN)) u_trsel (
    .bank  (in_tr_bank),
    .sel   (dec.tr_sel),
    .value (tr_val)
  );

  assign seq_pc    = in_pc + XLEN'(4);
  assign is_cmp    = (dec.kind == K_CMP_REG) || (dec.kind == K_CMP_IMM);
  assign legal     = !dec.bad;
  assign r_illegal = dec.bad;
  assign r_taken   = legal && ((is_cmp && cmp_hit) || dec.kind == K_LINK);
  assign r_likely  = legal && is_cmp && dec.hint;
  assign r_we      = legal && (dec.kind == K_LINK || dec.kind == K_MOVE);
  assign r_npc     = r_taken ? tr_val : seq_pc;
  assign r_ldata   = (dec.kind == K_LINK) ? (seq_pc | XLEN'(1)) : tr_val;

  assign pay_in = {r_taken, r_npc, r_likely, r_we, dec.dest, r_ldata, r_illegal};

  brt_out_stage #(.PW(PW), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_taken, out_next_pc, out_likely, out_link_we,
          out_link_dest, out_link_data, out_illegal} = pay_out;

  // R7: malformed words neither redirect nor write
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken && !out_link_we && !out_likely);

  // R4: the hint only accompanies compare-type results
  a_r4_hint_cmp_only: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && r_likely |-> is_cmp && !r_we);

  // R5: link writes are odd and always redirect
  a_r5_link_odd: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && r_we && dec.kind == K_LINK |-> r_ldata[0] && r_taken);

  // R6: reading a target register never redirects
  a_r6_move_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dec.kind == K_MOVE |-> !r_taken);

  // R8: foreign opcodes leave every action idle
  a_r8_foreign_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dec.kind == K_NONE |-> !r_taken && !r_we && !r_illegal);

  // R10: nothing is presented in the first cycle after reset
  a_r10_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !OUT_REG || !out_valid);

endmodule

// File: tb/test_brt_resolve_unit.sv
module test_brt_resolve_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       in_instr = '0;
  logic [XLEN-1:0]   in_opa = '0, in_opb = '0, in_pc = '0;
  logic [8*XLEN-1:0] in_tr_bank;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_taken, out_likely, out_link_we, out_illegal;
  logic [XLEN-1:0]   out_next_pc, out_link_data;
  logic [5:0]        out_link_dest;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brt_resolve_unit i_brt_resolve_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_opa(in_opa), .in_opb(in_opb), .in_pc(in_pc),
    .in_tr_bank(in_tr_bank), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_likely(out_likely),
    .out_link_we(out_link_we), .out_link_dest(out_link_dest),
    .out_link_data(out_link_data), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] tv(int i);
    return 64'hA000_0000_0000_0000 + 64'(i) * 64'h0000_0000_0101_0100;
  endfunction

  for (genvar g = 0; g < 8; g++) begin : g_bank
    assign in_tr_bank[g*64 +: 64] = tv(g);
  end

  function automatic logic [31:0] mk_cmp(logic [5:0] op, logic [3:0] ext,
                                         logic [5:0] rf, logic hint, logic [2:0] tr);
    return {op, 6'd2, ext, rf, hint, 2'b00, tr, 4'b0000};
  endfunction

  function automatic logic [31:0] mk_tg(logic [3:0] ext, logic [2:0] tr, logic [5:0] dst);
    return {6'd17, 3'b000, tr, ext, 6'h3f, dst, 4'b0000};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Send one instruction with the consumer ready; result is visible at the next falling edge.
  task automatic xfer(logic [31:0] ins, logic [63:0] a, logic [63:0] b, logic [63:0] pc);
    @(negedge clk);
    in_instr = ins; in_opa = a; in_opb = b; in_pc = pc;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(string tag, logic tk, logic [63:0] npc, logic lk,
                            logic we, logic [63:0] ld, logic il);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " taken"}, 64'(out_taken), 64'(tk));
    chk({tag, " next_pc"}, out_next_pc, npc);
    chk({tag, " likely"}, 64'(out_likely), 64'(lk));
    chk({tag, " link_we"}, 64'(out_link_we), 64'(we));
    if (we) chk({tag, " link_data"}, out_link_data, ld);
    chk({tag, " illegal"}, 64'(out_illegal), 64'(il));
  endtask

  localparam logic [63:0] PC0 = 64'h0000_0000_0000_1000;
  localparam logic [63:0] PC4 = 64'h0000_0000_0000_1004;
  localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic t_reset();
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_reg_compare();
    xfer(mk_cmp(6'd25, 4'd1, 6'd3, 1'b0, 3'd3), 64'd77, 64'd77, PC0);
    expect_res("R1/R3 eq true", 1, tv(3), 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd5, 6'd3, 1'b0, 3'd3), 64'd77, 64'd77, PC0);
    expect_res("R1/R3 ne false", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd3, 6'd3, 1'b0, 3'd1), NEG1, 64'd1, PC0);
    expect_res("R1 ge signed -1>=1", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd11, 6'd3, 1'b0, 3'd1), NEG1, 64'd1, PC0);
    expect_res("R1 geu max>=1", 1, tv(1), 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd3, 6'd3, 1'b0, 3'd6), 64'd9, 64'd9, PC0);
    expect_res("R1 ge equal", 1, tv(6), 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd7, 6'd3, 1'b0, 3'd2), 64'd9, 64'd9, PC0);
    expect_res("R1 gt equal", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd7, 6'd3, 1'b0, 3'd2), 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, PC0);
    expect_res("R1 gt 5>-3", 1, tv(2), 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd15, 6'd3, 1'b0, 3'd7), 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, PC0);
    expect_res("R1 gtu 5>big", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd25, 4'd15, 6'd3, 1'b0, 3'd7), 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, PC0);
    expect_res("R1 gtu big>5", 1, tv(7), 0, 0, 0, 0);
  endtask

  task automatic t_imm_compare();
    xfer(mk_cmp(6'd57, 4'd1, 6'h3f, 1'b0, 3'd4), NEG1, 64'd0, PC0);
    expect_res("R2 imm -1 eq all-ones", 1, tv(4), 0, 0, 0, 0);
    xfer(mk_cmp(6'd57, 4'd1, 6'h3f, 1'b0, 3'd4), 64'd63, 64'd63, PC0);
    expect_res("R2 imm sign-extended not 63", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd57, 4'd5, 6'd12, 1'b0, 3'd0), 64'd12, 64'd99, PC0);
    expect_res("R2 ne imm equal, opb ignored", 0, PC4, 0, 0, 0, 0);
    xfer(mk_cmp(6'd57, 4'd5, 6'd12, 1'b0, 3'd0), 64'd13, 64'd12, PC0);
    expect_res("R2 ne imm differ", 1, tv(0), 0, 0, 0, 0);
  endtask

  task automatic t_likely();
    xfer(mk_cmp(6'd25, 4'd1, 6'd3, 1'b1, 3'd5), 64'd1, 64'd1, PC0);
    expect_res("R4 hint on taken", 1, tv(5), 1, 0, 0, 0);
    xfer(mk_cmp(6'd57, 4'd1, 6'd1, 1'b1, 3'd5), 64'd0, 64'd0, PC0);
    expect_res("R4 hint on not taken", 0, PC4, 1, 0, 0, 0);
    xfer(mk_tg(4'd1, 3'd2, 6'h21), 64'd0, 64'd0, PC0);
    expect_res("R4 no hint on link (bit9 set via dest)", 1, tv(2), 0, 1, 64'h1005, 0);
  endtask

  task automatic t_link();
    xfer(mk_tg(4'd1, 3'd5, 6'd18), 64'd0, 64'd0, PC0);
    expect_res("R5 link", 1, tv(5), 0, 1, 64'h0000_0000_0000_1005, 0);
    chk("R5 link dest", 64'(out_link_dest), 64'd18);
    xfer(mk_tg(4'd1, 3'd0, 6'd1), 64'd0, 64'd0, 64'h0000_0000_0000_2003);
    expect_res("R5 link odd pc", 1, tv(0), 0, 1, 64'h0000_0000_0000_2007, 0);
  endtask

  task automatic t_move();
    xfer(mk_tg(4'd5, 3'd6, 6'd9), 64'd0, 64'd0, PC0);
    expect_res("R6 move target", 0, PC4, 0, 1, tv(6), 0);
    chk("R6 move dest", 64'(out_link_dest), 64'd9);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    w = mk_cmp(6'd25, 4'd1, 6'd3, 1'b1, 3'd3); w[8:7] = 2'b01;
    xfer(w, 64'd4, 64'd4, PC0);
    expect_res("R7 cmp bits 8:7", 0, PC4, 0, 0, 0, 1);
    w = mk_cmp(6'd25, 4'd9, 6'd3, 1'b0, 3'd3);
    xfer(w, 64'd4, 64'd4, PC0);
    expect_res("R7 cmp unknown ext", 0, PC4, 0, 0, 0, 1);
    w = mk_cmp(6'd57, 4'd3, 6'd4, 1'b0, 3'd3);
    xfer(w, 64'd9, 64'd4, PC0);
    expect_res("R7 imm ext 3", 0, PC4, 0, 0, 0, 1);
    w = mk_cmp(6'd57, 4'd1, 6'd4, 1'b0, 3'd3); w[2] = 1'b1;
    xfer(w, 64'd4, 64'd4, PC0);
    expect_res("R7 imm tail bits", 0, PC4, 0, 0, 0, 1);
    w = mk_tg(4'd1, 3'd2, 6'd7); w[24] = 1'b1;
    xfer(w, 64'd0, 64'd0, PC0);
    expect_res("R7 link bits 25:23", 0, PC4, 0, 0, 0, 1);
    w = mk_tg(4'd5, 3'd2, 6'd7); w[12] = 1'b0;
    xfer(w, 64'd0, 64'd0, PC0);
    expect_res("R7 move right field", 0, PC4, 0, 0, 0, 1);
    w = mk_tg(4'd3, 3'd2, 6'd7);
    xfer(w, 64'd0, 64'd0, PC0);
    expect_res("R7 target group ext 3", 0, PC4, 0, 0, 0, 1);
  endtask

  task automatic t_foreign();
    xfer({6'd0, 6'd2, 4'd9, 6'd3, 6'd4, 4'd0}, 64'd1, 64'd1, PC0);
    expect_res("R8 foreign opcode", 0, PC4, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    in_instr = mk_cmp(6'd25, 4'd1, 6'd3, 1'b0, 3'd1); in_opa = 64'd3; in_opb = 64'd3;
    in_pc = PC0; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R9 first result valid", 64'(out_valid), 64'd1);
    chk("R9 first next_pc", out_next_pc, tv(1));
    chk("R9 in_ready low when stalled", 64'(in_ready), 64'd0);
    in_instr = mk_cmp(6'd25, 4'd5, 6'd3, 1'b0, 3'd2); in_opa = 64'd3; in_opb = 64'd3;
    @(negedge clk);
    chk("R9 held next_pc", out_next_pc, tv(1));
    chk("R9 held taken", 64'(out_taken), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result valid", 64'(out_valid), 64'd1);
    chk("R9 second next_pc", out_next_pc, PC4);
    chk("R9 second taken", 64'(out_taken), 64'd0);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_compare();
    t_imm_compare();
    t_likely();
    t_link();
    t_move();
    t_illegal();
    t_foreign();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule